// File: doc/BRIEF.md
# Cascaded Two-Level Interrupt Controller

This block gathers up to sixty-four interrupt sources into one CPU interrupt line. Thirty-two of them feed a primary controller directly. The other thirty-two feed a secondary controller, which reports into three summary bits of the primary status. Each source is either level-sensitive or edge-latched, and this is fixed per bit. A level bit mirrors its synchronised input. An edge bit is set by a rising input and stays set until software clears it.

Software reaches the block through a small synchronous register bus. It reads the status words, writes the two enable masks, and clears edge latches. To clear a latch, it writes back a status image in which that bit is 0. The block also computes a combined vector, so a handler can find the source to serve without walking both levels. When a primary summary bit is active, the vector points into the secondary range. A valid flag marks a read that found nothing pending.

Top module: `casc_irq_ctrl`

## Requirements
- R1: `cpu_irq` is high exactly when the primary status ANDed with the primary mask is non-zero.
- R2: Level bits follow their input after two synchronising clocks. Primary edge bits are 16-19, 22-24 and 28-31. They latch on a 0-to-1 input transition and stay set after the input returns low.
- R3: A write to the primary latch register (address 2) clears each primary edge bit whose data bit is 0. Data bits at 1 keep their latch, and level bits are not affected. Reading address 2 returns only the latched edge bits.
- R4: Primary status bit 6 is the OR of secondary bits 0-7 ANDed with the secondary mask. Bit 5 covers secondary bits 8-15 and bit 4 covers 16-31. The primary input pins at positions 4-6 have no effect.
- R5: Secondary bits 16, 22 and 28 are edge-latched. A write to the secondary status register (address 3) clears each of them whose data bit is 0. All other secondary bits are level bits.
- R6: After reset, both masks and every latched status bit read zero and `cpu_irq` is low.
- R7: With no summary bit active, the vector is the index of the lowest set bit of the masked primary status.
- R8: When any masked summary bit (4-6) is active, the vector is 32 plus the index of the lowest set bit of the masked secondary status. This holds even if a lower primary bit is also active.
- R9: When no masked primary bit is pending, `vec_valid` is low and `vec_num` is 0. `vec_valid` always equals `cpu_irq`.
- R10: If a rising edge is detected in the same clock as a clearing write to that bit, the latch stays set.
- R11: The register map is: 0 primary status, 1 primary mask, 2 primary latch, 3 secondary status, 4 secondary mask, 5 vector. The vector word holds the valid flag in bit 31 and the vector in bits 5:0. Writes to addresses 0 and 5 are ignored. A mask write takes effect on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pri_src | input | 32 | Primary interrupt sources (bits 4-6 unused) |
| sec_src | input | 32 | Secondary interrupt sources |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data (combinational on addr) |
| cpu_irq | output | 1 | Interrupt line to the CPU |
| vec_valid | output | 1 | A masked source is pending |
| vec_num | output | 6 | Combined lowest pending vector |

## Verification
The hardest case to reach from the ports is an edge and a clearing write landing in the same clock, as R10 describes. The edge is only seen two synchroniser stages after the pin changes. The bench raises the pin on a falling clock edge and waits two falling edges. It then drives the clearing write so that the write is sampled on the same rising edge as the internal edge detection. The other hard case is a summary bit overriding a lower primary bit. The bench reaches it by enabling primary bit 0 and a secondary group at the same time.

// File: rtl/casc_irq_pkg.sv
// Package: shared constants for the cascaded interrupt controller.
// Assumes a 32-bit source word on both levels; the summary bit
// positions and group slices are fixed by the controller's behaviour.
package casc_irq_pkg;
    localparam int SRC_W   = 32;
    localparam int IDX_W   = $clog2(SRC_W);
    localparam int VEC_W   = IDX_W + 1;
    localparam int ADDR_W  = 3;

    // primary positions that carry secondary group summaries
    localparam int SUM_HI_BIT  = 6;   // secondary 0-7
    localparam int SUM_MID_BIT = 5;   // secondary 8-15
    localparam int SUM_LO_BIT  = 4;   // secondary 16-31
    localparam logic [SRC_W-1:0] SUM_MASK = 32'h0000_0070;

    // register addresses
    typedef enum logic [ADDR_W-1:0] {
        REG_PSTAT = 3'd0,
        REG_PMASK = 3'd1,
        REG_PLAT  = 3'd2,
        REG_SSTAT = 3'd3,
        REG_SMASK = 3'd4,
        REG_VEC   = 3'd5
    } reg_addr_e;
endpackage

// File: rtl/irq_src_bank.sv
// Module: irq_src_bank
// Synchronises a word of interrupt inputs and forms the status word.
// Bits selected by EDGE_MASK latch on a rising synchronised input and
// clear on a clear request unless an edge arrives in the same clock.
// Other bits mirror the last synchroniser stage. Assumes SYNC >= 2.
module irq_src_bank #(
    parameter int               W         = 32,
    parameter int               SYNC      = 2,
    parameter logic [W-1:0]     EDGE_MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    input  logic [W-1:0] clr_req,
    output logic [W-1:0] stat_o
);
    logic [W-1:0] sync_q [SYNC];
    logic [W-1:0] prev_q;
    logic [W-1:0] rise;

    // shift inputs through the synchroniser chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < SYNC; k++) sync_q[k] <= '0;
        end else begin
            sync_q[0] <= raw_in;
            for (int k = 1; k < SYNC; k++) sync_q[k] <= sync_q[k-1];
        end
    end

    // remember the previous synchronised value for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_q[SYNC-1];
    end

    // 0-to-1 transitions seen this clock
    always_comb rise = sync_q[SYNC-1] & ~prev_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (EDGE_MASK[i]) begin : g_edge
            logic lat_q;
            // edge latch: a new edge outranks a clear in the same clock
            always_ff @(posedge clk) begin
                if (!rst_n)          lat_q <= 1'b0;
                else if (rise[i])    lat_q <= 1'b1;
                else if (clr_req[i]) lat_q <= 1'b0;
            end
            assign stat_o[i] = lat_q;
        end else begin : g_level
            assign stat_o[i] = sync_q[SYNC-1][i];
        end
    end
endmodule

// File: rtl/irq_first_set.sv
// Module: irq_first_set
// Finds the index of the lowest set bit of a word and flags whether
// any bit is set. Index is zero when the word is empty.
module irq_first_set #(
    parameter int W  = 32,
    localparam int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_in,
    output logic [IW-1:0] idx_o,
    output logic          any_o
);
    // scan from the top so the lowest set bit is written last
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_in[i]) idx_o = IW'(i);
        end
        any_o = |vec_in;
    end
endmodule

// File: rtl/irq_reg_if.sv
// Module: irq_reg_if
// Register file of the controller: holds both masks, turns writes to
// the latch and secondary status addresses into per-bit clear requests
// for edge bits, and multiplexes the read data. Reads are
// combinational on the address; writes take effect on the clock edge.
module irq_reg_if
    import casc_irq_pkg::*;
#(
    parameter logic [SRC_W-1:0] PRI_EDGE = '0,
    parameter logic [SRC_W-1:0] SEC_EDGE = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    input  logic [SRC_W-1:0]  pstat,
    input  logic [SRC_W-1:0]  sstat,
    input  logic              vec_valid,
    input  logic [VEC_W-1:0]  vec_num,
    output logic [SRC_W-1:0]  pmask,
    output logic [SRC_W-1:0]  smask,
    output logic [SRC_W-1:0]  pclr,
    output logic [SRC_W-1:0]  sclr,
    output logic [SRC_W-1:0]  rdata
);
    logic wr_pmask, wr_smask, wr_plat, wr_sstat;

    // decode the write strobe per register
    always_comb begin
        wr_pmask = wr_en && (addr == REG_PMASK);
        wr_smask = wr_en && (addr == REG_SMASK);
        wr_plat  = wr_en && (addr == REG_PLAT);
        wr_sstat = wr_en && (addr == REG_SSTAT);
    end

    // mask registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pmask <= '0;
            smask <= '0;
        end else begin
            if (wr_pmask) pmask <= wdata;
            if (wr_smask) smask <= wdata;
        end
    end

    // zero bits in the written image clear edge latches only
    always_comb begin
        pclr = wr_plat  ? (~wdata & PRI_EDGE) : '0;
        sclr = wr_sstat ? (~wdata & SEC_EDGE) : '0;
    end

    // read multiplexer
    always_comb begin
        unique case (addr)
            REG_PSTAT: rdata = pstat;
            REG_PMASK: rdata = pmask;
            REG_PLAT:  rdata = pstat & PRI_EDGE;
            REG_SSTAT: rdata = sstat;
            REG_SMASK: rdata = smask;
            REG_VEC:   rdata = {vec_valid, {(SRC_W-1-VEC_W){1'b0}}, vec_num};
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/casc_irq_ctrl.sv
// Module: casc_irq_ctrl (top)
// Two-level interrupt controller. The secondary bank's masked status
// is folded into three summary bits of the primary status; the
// primary masked status drives the CPU line and, with the secondary,
// the combined lowest-pending vector. Inputs are asynchronous and
// are synchronised inside; the register bus is synchronous to clk.
module casc_irq_ctrl
    import casc_irq_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [SRC_W-1:0] PRI_EDGE    = 32'hF1CF_0000,
    parameter logic [SRC_W-1:0] SEC_EDGE    = 32'h1041_0000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SRC_W-1:0]  pri_src,
    input  logic [SRC_W-1:0]  sec_src,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SRC_W-1:0]  wdata,
    output logic [SRC_W-1:0]  rdata,
    output logic              cpu_irq,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_num
);
    logic [SRC_W-1:0] pmask, smask, pclr, sclr;
    logic [SRC_W-1:0] pbank, sstat, pstat;
    logic [SRC_W-1:0] pact, sact;
    logic [IDX_W-1:0] pidx, sidx;
    logic             pany, sany, sum_hit;

    irq_src_bank #(.W(SRC_W), .SYNC(SYNC_STAGES), .EDGE_MASK(PRI_EDGE & ~SUM_MASK))
    u_pri (.clk(clk), .rst_n(rst_n), .raw_in(pri_src & ~SUM_MASK),
           .clr_req(pclr), .stat_o(pbank));

    irq_src_bank #(.W(SRC_W), .SYNC(SYNC_STAGES), .EDGE_MASK(SEC_EDGE))
    u_sec (.clk(clk), .rst_n(rst_n), .raw_in(sec_src),
           .clr_req(sclr), .stat_o(sstat));

    // secondary enable and group summaries placed into the primary word
    always_comb begin
        sact  = sstat & smask;
        pstat = pbank & ~SUM_MASK;
        pstat[SUM_HI_BIT]  = |sact[7:0];
        pstat[SUM_MID_BIT] = |sact[15:8];
        pstat[SUM_LO_BIT]  = |sact[31:16];
        pact  = pstat & pmask;
    end

    irq_first_set #(.W(SRC_W)) u_pfind (.vec_in(pact), .idx_o(pidx), .any_o(pany));
    irq_first_set #(.W(SRC_W)) u_sfind (.vec_in(sact), .idx_o(sidx), .any_o(sany));

    // line, valid flag and combined vector
    always_comb begin
        cpu_irq   = |pact;
        sum_hit   = |(pact & SUM_MASK);
        vec_valid = pany;
        if (!pany)                 vec_num = '0;
        else if (sum_hit && sany)  vec_num = {1'b1, sidx};
        else                       vec_num = {1'b0, pidx};
    end

    irq_reg_if #(.PRI_EDGE(PRI_EDGE & ~SUM_MASK), .SEC_EDGE(SEC_EDGE))
    u_regs (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
            .pstat(pstat), .sstat(sstat), .vec_valid(vec_valid), .vec_num(vec_num),
            .pmask(pmask), .smask(smask), .pclr(pclr), .sclr(sclr), .rdata(rdata));
endmodule

// File: rtl/casc_irq_chk.sv
// Module: casc_irq_chk
// Assertion checker for casc_irq_ctrl, attached by bind below.
module casc_irq_chk
    import casc_irq_pkg::*;
#(
    parameter logic [SRC_W-1:0] PRI_EDGE = 32'hF1CF_0000,
    parameter logic [SRC_W-1:0] SEC_EDGE = 32'h1041_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [SRC_W-1:0]  wdata,
    input logic              cpu_irq,
    input logic              vec_valid,
    input logic [VEC_W-1:0]  vec_num,
    input logic [SRC_W-1:0]  pstat,
    input logic [SRC_W-1:0]  sstat,
    input logic [SRC_W-1:0]  pmask,
    input logic [SRC_W-1:0]  smask
);
    localparam logic [SRC_W-1:0] PE = PRI_EDGE & ~SUM_MASK;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pmask == '0 && smask == '0 && (pstat & PE) == '0 && (sstat & SEC_EDGE) == '0)); // R6
    AST_LINE_VALID_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_irq == vec_valid); // R9
    AST_IDLE_VEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !vec_valid |-> vec_num == '0); // R9
    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == 3'd1) |=> pmask == $past(wdata)); // R11
    AST_PRI_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd2) |=> ((pstat & $past(pstat) & PE) == ($past(pstat) & PE))); // R3
    AST_SEC_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == 3'd3) |=> ((sstat & $past(sstat) & SEC_EDGE) == ($past(sstat) & SEC_EDGE))); // R5
    AST_SUMMARY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (smask == '0) |-> (pstat[6:4] == 3'b000)); // R4
    AST_VEC_FROM_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
        (vec_valid && vec_num[VEC_W-1]) |-> ((pstat[6:4] & pmask[6:4]) != 3'b000)); // R8
endmodule

bind casc_irq_ctrl casc_irq_chk #(.PRI_EDGE(PRI_EDGE), .SEC_EDGE(SEC_EDGE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_num(vec_num),
    .pstat(pstat), .sstat(sstat), .pmask(pmask), .smask(smask));

// File: tb/sim_casc_irq_ctrl.sv
module sim_casc_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pri_src = '0, sec_src = '0, wdata = '0;
    logic        wr_en = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] rdata;
    logic        cpu_irq, vec_valid;
    logic [5:0]  vec_num;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;   // 250 MHz

    casc_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .pri_src(pri_src), .sec_src(sec_src),
        .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .cpu_irq(cpu_irq), .vec_valid(vec_valid), .vec_num(vec_num));

    // stimulus: pri_src, sec_src, pmask, smask -> irq, valid, vector (level bits only)
    typedef struct packed {
        logic [31:0] p_in; logic [31:0] s_in; logic [31:0] pm; logic [31:0] sm;
        logic irq; logic vld; logic [5:0] vec;
    } vec_t;
    localparam int NV = 10;
    localparam vec_t TBL [NV] = '{
        '{32'h0000_0001, 32'h0, 32'hFFFF_FFFF, 32'h0, 1'b1, 1'b1, 6'd0},   // R7
        '{32'h0000_0300, 32'h0, 32'h0000_0200, 32'h0, 1'b1, 1'b1, 6'd9},   // R7
        '{32'h0800_0000, 32'h0, 32'h0,         32'h0, 1'b0, 1'b0, 6'd0},   // R1
        '{32'h0000_0070, 32'h0, 32'h0000_0070, 32'h0, 1'b0, 1'b0, 6'd0},   // R4 pins ignored
        '{32'h0, 32'h0000_0100, 32'h0000_0020, 32'h0000_0100, 1'b1, 1'b1, 6'd40}, // R4
        '{32'h0, 32'h0000_0100, 32'h0000_0040, 32'h0000_0100, 1'b0, 1'b0, 6'd0},  // R4
        '{32'h0000_0001, 32'h0000_0008, 32'h0000_0041, 32'h0000_00FF, 1'b1, 1'b1, 6'd35}, // R8
        '{32'h0, 32'h8000_0000, 32'h0000_0010, 32'h8000_0000, 1'b1, 1'b1, 6'd63}, // R8
        '{32'h0200_0000, 32'h0, 32'h0200_0000, 32'h0, 1'b1, 1'b1, 6'd25},  // R7
        '{32'h0, 32'h0002_0000, 32'h0000_0070, 32'h0, 1'b0, 1'b0, 6'd0}    // R9
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk); wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk); addr = a; #1 d = rdata;
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R6 reset state
        bus_rd(3'd1, r); check("R6 pmask", r, 32'h0);
        bus_rd(3'd4, r); check("R6 smask", r, 32'h0);
        bus_rd(3'd2, r); check("R6 latch", r, 32'h0);
        check("R6 irq", {31'b0, cpu_irq}, 32'h0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            bus_wr(3'd1, TBL[i].pm);
            bus_wr(3'd4, TBL[i].sm);
            @(negedge clk); pri_src = TBL[i].p_in; sec_src = TBL[i].s_in;
            settle();
            check("R1/R7/R8/R9 table", {24'b0, cpu_irq, vec_valid, vec_num},
                  {24'b0, TBL[i].irq, TBL[i].vld, TBL[i].vec});
        end
        // R11 vector register word, last entry: 25 at bit 31 valid
        pri_src = 32'h0200_0000; sec_src = '0;
        bus_wr(3'd1, 32'h0200_0000);
        settle();
        bus_rd(3'd5, r); check("R11 vec reg", r, 32'h8000_0019);
        // R2 level bit follows its input down
        pri_src = '0; settle();
        check("R2 level falls", {31'b0, cpu_irq}, 32'h0);

        // R2 edge latch on bits 16 and 17
        bus_wr(3'd1, 32'h0);
        @(negedge clk); pri_src = 32'h0003_0000; settle();
        pri_src = '0; settle();
        bus_rd(3'd2, r); check("R2 edge held", r, 32'h0003_0000);
        // R3 clear bit 16 only
        bus_wr(3'd2, 32'hFFFE_FFFF); settle();
        bus_rd(3'd2, r); check("R3 selective clear", r, 32'h0002_0000);
        // R3 level bit unaffected by a clear write
        pri_src = 32'h0000_0001; settle();
        bus_wr(3'd2, 32'h0); settle();
        bus_rd(3'd0, r); check("R3 level kept", r, 32'h0000_0001);
        pri_src = '0; settle();
        // R11 writes to status and vector ignored
        bus_wr(3'd0, 32'h0); bus_wr(3'd5, 32'hFFFF_FFFF);
        @(negedge clk); pri_src = 32'h0004_0000; settle(); pri_src = '0; settle();
        bus_wr(3'd0, 32'h0); settle();
        bus_rd(3'd2, r); check("R11 status write ignored", r, 32'h0004_0000);
        bus_wr(3'd2, 32'h0);

        // R5 secondary edge bit 22
        @(negedge clk); sec_src = 32'h0040_0001; settle(); sec_src = '0; settle();
        bus_rd(3'd3, r); check("R5 sec edge latched", r, 32'h0040_0000);
        bus_wr(3'd3, 32'hFFBF_FFFF); settle();
        bus_rd(3'd3, r); check("R5 sec edge cleared", r, 32'h0);

        // R10 edge in the same clock as a clear of bit 28
        @(negedge clk); pri_src = 32'h1000_0000;
        @(negedge clk);
        @(negedge clk); wr_en = 1'b1; addr = 3'd2; wdata = 32'h0;
        @(negedge clk); wr_en = 1'b0;
        pri_src = '0; settle();
        bus_rd(3'd2, r); check("R10 edge wins", r, 32'h1000_0000);
        bus_wr(3'd2, 32'h0); settle();
        bus_rd(3'd2, r); check("R3 clear without edge", r, 32'h0);

        // R1 latched edge raises the line once enabled
        @(negedge clk); pri_src = 32'h8000_0000; settle(); pri_src = '0;
        bus_wr(3'd1, 32'h8000_0000); settle();
        check("R1 edge line", {24'b0, cpu_irq, vec_valid, vec_num}, {24'b0, 2'b11, 6'd31});

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule